// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit half of a descriptor-driven network controller. Software builds a ring of 16-byte descriptors in memory and programs the ring's base address. It then writes a one-shot poll command. The engine walks the ring from its current position. Each descriptor it owns has its buffer streamed out, one frame at a time, as little-endian bytes on a ready/valid byte stream. The engine then writes the descriptor's status word back with the ownership bit cleared and records completion in an interrupt status register. The scan stops at the first descriptor that software has not handed over.

A descriptor holds four 32-bit words: status/control at +0, a tag word at +4 (not used here), the buffer address low word at +8 and the high word at +12. In the status word, bit 31 means the engine owns the descriptor. Bit 30 marks the last entry of the ring. Bits 29 and 28 flag the first and last segment of a frame. The low `LEN_W` bits hold the frame length in bytes. Only single-segment frames are carried, and buffers start on a 4-byte boundary. Memory is reached through a single-outstanding word request port, and each request is held until it is acknowledged.

Top module: `tx_poll_engine`

## Requirements
- R1: After reset, `mem_req`, `tx_valid` and `irq` are low, and the control and interrupt status registers (word indices 2 and 4) read zero.
- R2: The ring base is word 0 (low) and word 1 (high). Bits 7:0 of the low word always read zero. The first fetch after a poll reads the status word at the current descriptor address, which equals the base after the base is written.
- R3: For an owned, well-formed descriptor, exactly `length` bytes are emitted. Bytes go in ascending address order, taken little-endian from each buffer word. `tx_last` is high on the final byte only.
- R4: After a frame, the status word is written back to the descriptor address with bit 31 cleared and all other bits kept. Interrupt status bit 0 (done) is then set.
- R5: A fetched status word with bit 31 clear ends the scan. The engine returns to idle, and interrupt status bit 2 (unavailable) is set.
- R6: After a descriptor with bit 30 set, the next descriptor address is the ring base. Otherwise it is the previous address plus 16.
- R7: A descriptor that is owned but has length 0, or lacks bit 29 or bit 28, emits no bytes. It is still written back with bit 31 cleared, and interrupt status bit 1 (error) is set.
- R8: Writing the interrupt status register (word 4) clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R9: A poll (word 3, bit 0 written as 1) while transmit enable (word 2, bit 0) is 0 is discarded. No memory request follows, and the interrupt status is unchanged.
- R10: Writing 1 to control bit 1 performs a soft reset. The reset bit clears itself after one cycle, transmit enable and interrupt status are cleared, and the next scan begins at the ring base.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R12: `irq` is high whenever any interrupt status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| irq | output | 1 | Any interrupt status bit set |

## Verification
The first pattern is a three-entry ring with lengths 5, 8 and 1, ending on an end-of-ring mark. It separates partial from whole final words, and it shows both the +16 advance and the wrap back to the base. A second frame is sent under an irregular ready pattern, which shows that byte order and `tx_last` survive stalls. A ring with a missing first-segment flag and a zero length shows that bad descriptors are written back without any output. A disabled poll and a soft reset in mid-ring show the start position and the absence of memory traffic.

// File: rtl/tx_poll_pkg.sv
// Shared constants and types of the transmit descriptor poll engine.
// Assumes descriptors are 16 bytes and status bit positions are fixed.
package tx_poll_pkg;

    localparam int ADDR_W      = 64;
    localparam int DESC_BYTES  = 16;

    // status word bit positions
    localparam int OWN_BIT = 31;
    localparam int EOR_BIT = 30;
    localparam int FS_BIT  = 29;
    localparam int LS_BIT  = 28;

    // register word indices
    localparam logic [2:0] REG_BASE_LO = 3'd0;
    localparam logic [2:0] REG_BASE_HI = 3'd1;
    localparam logic [2:0] REG_CTRL    = 3'd2;
    localparam logic [2:0] REG_POLL    = 3'd3;
    localparam logic [2:0] REG_IRQ     = 3'd4;

    // interrupt status bit positions
    localparam int IRQ_DONE    = 0;
    localparam int IRQ_ERR     = 1;
    localparam int IRQ_UNAVAIL = 2;
    localparam int IRQ_W       = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT,
        ST_ALO,
        ST_AHI,
        ST_BUF,
        ST_SEND,
        ST_WB
    } fsm_state_t;

endpackage

// File: rtl/tx_poll_regs.sv
// Register file: ring base, control (enable, self-clearing soft reset),
// one-shot poll and write-one-to-clear interrupt status.
// Assumes full-word writes; read data is combinational on reg_addr.
module tx_poll_regs
    import tx_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_done,
    input  logic              ev_err,
    input  logic              ev_unavail,
    output logic [ADDR_W-1:0] ring_base,
    output logic              base_load,
    output logic              tx_en,
    output logic              soft_rst,
    output logic              poll_req,
    output logic              irq
);

    logic [31:8]       base_lo_q;
    logic [31:0]       base_hi_q;
    logic              tx_en_q;
    logic              soft_rst_q;
    logic              base_wr_q;
    logic [IRQ_W-1:0]  irq_q;
    logic [IRQ_W-1:0]  irq_set;
    logic [IRQ_W-1:0]  irq_clr;
    logic              wr_lo, wr_hi, wr_ctrl, wr_irq;
    logic              unused_wbits;

    assign wr_lo   = reg_wr && (reg_addr == REG_BASE_LO);
    assign wr_hi   = reg_wr && (reg_addr == REG_BASE_HI);
    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_irq  = reg_wr && (reg_addr == REG_IRQ);

    assign poll_req  = reg_wr && (reg_addr == REG_POLL) && reg_wdata[0];
    assign irq_set   = {ev_unavail, ev_err, ev_done};
    assign irq_clr   = wr_irq ? reg_wdata[IRQ_W-1:0] : '0;
    assign unused_wbits = ^reg_wdata[7:3];

    // Ring base storage, low byte forced to zero for 256-byte alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else begin
            if (wr_lo) base_lo_q <= reg_wdata[31:8];
            if (wr_hi) base_hi_q <= reg_wdata;
        end
    end

    // Delayed base-write pulse so the walker loads the new value.
    always_ff @(posedge clk) begin
        if (!rst_n) base_wr_q <= 1'b0;
        else        base_wr_q <= wr_lo || wr_hi;
    end

    // Control bits: enable and a one-cycle soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q    <= 1'b0;
            soft_rst_q <= 1'b0;
        end else if (soft_rst_q) begin
            tx_en_q    <= 1'b0;
            soft_rst_q <= 1'b0;
        end else if (wr_ctrl) begin
            tx_en_q    <= reg_wdata[0];
            soft_rst_q <= reg_wdata[1];
        end
    end

    // Interrupt status: events set, written ones clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_q) irq_q <= '0;
        else                      irq_q <= (irq_q & ~irq_clr) | irq_set;
    end

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            REG_BASE_LO: reg_rdata = {base_lo_q, 8'h00};
            REG_BASE_HI: reg_rdata = base_hi_q;
            REG_CTRL:    reg_rdata = {30'd0, soft_rst_q, tx_en_q};
            REG_IRQ:     reg_rdata = {{(32-IRQ_W){1'b0}}, irq_q};
            default:     reg_rdata = 32'd0;
        endcase
    end

    assign ring_base = {base_hi_q, base_lo_q, 8'h00};
    assign base_load = base_wr_q;
    assign tx_en     = tx_en_q;
    assign soft_rst  = soft_rst_q;
    assign irq       = |irq_q;

endmodule

// File: rtl/tx_poll_stream.sv
// Word-to-byte serializer: emits 1..4 bytes of a loaded word, lowest
// byte first, under ready/valid. Assumes load only while idle.
module tx_poll_stream (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        load,
    input  logic [31:0] ld_word,
    input  logic [2:0]  ld_count,
    input  logic        ld_last,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last
);

    logic [31:0] word_q;
    logic [2:0]  cnt_q;
    logic [1:0]  idx_q;
    logic        last_q;
    logic        valid_q;
    logic        at_end;

    assign at_end = ({1'b0, idx_q} == (cnt_q - 3'd1));

    // Hold the word and step the byte index on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            word_q  <= '0;
            cnt_q   <= 3'd0;
            idx_q   <= 2'd0;
            last_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (load) begin
            word_q  <= ld_word;
            cnt_q   <= ld_count;
            idx_q   <= 2'd0;
            last_q  <= ld_last;
            valid_q <= 1'b1;
        end else if (valid_q && tx_ready) begin
            if (at_end) valid_q <= 1'b0;
            else        idx_q   <= idx_q + 2'd1;
        end
    end

    assign tx_valid = valid_q;
    assign tx_data  = word_q[{idx_q, 3'b000} +: 8];
    assign tx_last  = valid_q && last_q && at_end;

endmodule

// File: rtl/tx_poll_fsm.sv
// Descriptor walker: fetches status and buffer address, streams the
// buffer through the serializer, writes status back with ownership
// cleared and moves to the next entry. Assumes word-aligned buffers
// and a memory port that acknowledges each held request once.
module tx_poll_fsm
    import tx_poll_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_en,
    input  logic              poll_req,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              base_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              ser_busy,
    output logic              ser_load,
    output logic [2:0]        ser_count,
    output logic              ser_last,
    output logic              ev_done,
    output logic              ev_err,
    output logic              ev_unavail
);

    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

    fsm_state_t        state_q;
    logic [ADDR_W-1:0] desc_q;
    logic [ADDR_W-1:0] buf_q;
    logic [31:0]       status_q;
    logic [LEN_W-1:0]  remain_q;
    logic              err_q;
    logic              poll_q;
    logic              frame_ok;
    logic              wb_ack;

    assign frame_ok = (mem_rdata[LEN_W-1:0] != '0) &&
                      mem_rdata[FS_BIT] && mem_rdata[LS_BIT];
    assign wb_ack   = (state_q == ST_WB) && mem_ack;

    // Pending poll: kept only while transmit is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !tx_en)        poll_q <= 1'b0;
        else if (poll_req)                       poll_q <= 1'b1;
        else if (state_q == ST_IDLE && poll_q)   poll_q <= 1'b0;
    end

    // Main walker state and descriptor pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            desc_q   <= '0;
            buf_q    <= '0;
            status_q <= '0;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else if (soft_rst) begin
            state_q  <= ST_IDLE;
            desc_q   <= ring_base;
            err_q    <= 1'b0;
        end else begin
            if (base_load && state_q == ST_IDLE) desc_q <= ring_base;
            case (state_q)
                ST_IDLE: if (poll_q) state_q <= ST_STAT;
                ST_STAT: if (mem_ack) begin
                    status_q <= mem_rdata;
                    remain_q <= mem_rdata[LEN_W-1:0];
                    if (!mem_rdata[OWN_BIT]) begin
                        state_q <= ST_IDLE;
                    end else if (!frame_ok) begin
                        err_q   <= 1'b1;
                        state_q <= ST_WB;
                    end else begin
                        err_q   <= 1'b0;
                        state_q <= ST_ALO;
                    end
                end
                ST_ALO: if (mem_ack) begin
                    buf_q[31:0] <= {mem_rdata[31:2], 2'b00};
                    state_q     <= ST_AHI;
                end
                ST_AHI: if (mem_ack) begin
                    buf_q[ADDR_W-1:32] <= mem_rdata;
                    state_q            <= ST_BUF;
                end
                ST_BUF: if (mem_ack) begin
                    remain_q <= remain_q - {{(LEN_W-3){1'b0}}, ser_count};
                    buf_q    <= buf_q + ADDR_W'(4);
                    state_q  <= ST_SEND;
                end
                ST_SEND: if (!ser_busy) begin
                    state_q <= (remain_q == '0) ? ST_WB : ST_BUF;
                end
                ST_WB: if (mem_ack) begin
                    desc_q  <= status_q[EOR_BIT] ? ring_base
                                                 : desc_q + ADDR_W'(DESC_BYTES);
                    state_q <= tx_en ? ST_STAT : ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory request decode per state.
    always_comb begin
        mem_req = 1'b1;
        mem_we  = 1'b0;
        case (state_q)
            ST_STAT: mem_addr = desc_q;
            ST_ALO:  mem_addr = desc_q + ADDR_W'(8);
            ST_AHI:  mem_addr = desc_q + ADDR_W'(12);
            ST_BUF:  mem_addr = buf_q;
            ST_WB: begin
                mem_addr = desc_q;
                mem_we   = 1'b1;
            end
            default: begin
                mem_addr = desc_q;
                mem_req  = 1'b0;
            end
        endcase
    end

    // Chunk size of the next buffer word and write-back data.
    always_comb begin
        ser_count = (remain_q >= WORD_BYTES) ? 3'd4 : remain_q[2:0];
        ser_last  = (remain_q <= WORD_BYTES);
        mem_wdata = status_q & ~(32'd1 << OWN_BIT);
    end

    assign ser_load   = (state_q == ST_BUF) && mem_ack;
    assign ev_unavail = (state_q == ST_STAT) && mem_ack && !mem_rdata[OWN_BIT];
    assign ev_done    = wb_ack && !err_q;
    assign ev_err     = wb_ack && err_q;

endmodule

// File: rtl/tx_poll_engine.sv
// Top of the transmit descriptor poll engine: register file, ring
// walker and byte serializer. Assumes a single memory master port with
// one outstanding request and a byte sink with ready/valid.
module tx_poll_engine
    import tx_poll_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              irq
);

    logic [ADDR_W-1:0] ring_base;
    logic              base_load;
    logic              tx_en;
    logic              soft_rst;
    logic              poll_req;
    logic              ev_done, ev_err, ev_unavail;
    logic              ser_load, ser_last;
    logic [2:0]        ser_count;

    tx_poll_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ev_done    (ev_done),
        .ev_err     (ev_err),
        .ev_unavail (ev_unavail),
        .ring_base  (ring_base),
        .base_load  (base_load),
        .tx_en      (tx_en),
        .soft_rst   (soft_rst),
        .poll_req   (poll_req),
        .irq        (irq)
    );

    tx_poll_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .tx_en      (tx_en),
        .poll_req   (poll_req),
        .ring_base  (ring_base),
        .base_load  (base_load),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .ser_busy   (tx_valid),
        .ser_load   (ser_load),
        .ser_count  (ser_count),
        .ser_last   (ser_last),
        .ev_done    (ev_done),
        .ev_err     (ev_err),
        .ev_unavail (ev_unavail)
    );

    tx_poll_stream u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (soft_rst),
        .load     (ser_load),
        .ld_word  (mem_rdata),
        .ld_count (ser_count),
        .ld_last  (ser_last),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last)
    );

endmodule

// File: rtl/tx_poll_engine_chk.sv
// Protocol checker for the poll engine, bound to the top module.
module tx_poll_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [63:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last
);

    // R11: a stalled byte stays put
    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !soft_rst |=>
            tx_valid && $stable(tx_data) && $stable(tx_last));

    // R3: last marker only on a valid byte
    a_r3_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R4: write-back never hands ownership to the engine again
    a_r4_wb_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    // R2: every access is word aligned
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R2: a request is held unchanged until acknowledged
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !soft_rst |=>
            mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10: the soft reset bit lasts one cycle
    a_r10_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

endmodule

bind tx_poll_engine tx_poll_engine_chk u_chk (.*);

// File: tb/tx_poll_engine_tb.sv
// Scoreboard bench: setup tasks push expected bytes and write-backs,
// the memory model and byte monitor pop and compare them.
module tx_poll_engine_tb;

    localparam int BASE = 32'h100;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] EOR = 32'h4000_0000;
    localparam logic [31:0] FS  = 32'h2000_0000;
    localparam logic [31:0] LS  = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        tx_valid, tx_last, irq;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;

    logic [31:0] mem [0:1023];
    logic [8:0]  exp_bytes [$];
    logic [63:0] exp_wb [$];
    logic [31:0] rd_log [$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          n_access = 0;
    int          cyc = 0;
    int          ready_mode = 0;

    always #10 clk = ~clk;

    tx_poll_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "watchdog", 64'(cyc), 64'd100000);
            finish_run();
        end
    end

    // Memory model: acknowledges a held request at a falling edge.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (rst_n && mem_req) begin
            n_access++;
            mem_ack <= 1'b1;
            if (mem_we) begin
                if (exp_wb.size() == 0) begin
                    check(1'b0, "R4 unexpected write-back", {mem_addr[31:0], mem_wdata}, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = exp_wb.pop_front();
                    check({mem_addr[31:0], mem_wdata} == e, "R4/R6/R7 write-back",
                          {mem_addr[31:0], mem_wdata}, e);
                end
                mem[mem_addr[11:2]] = mem_wdata;
            end else begin
                rd_log.push_back(mem_addr[31:0]);
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    // Ready driver then byte monitor, in one process to fix their order.
    always @(negedge clk) begin
        if (ready_mode == 1) tx_ready <= 1'b1;
        else                 tx_ready <= ((cyc % 3) != 0);
        #1;
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_bytes.size() == 0) begin
                check(1'b0, "R3 unexpected byte", {55'd0, tx_last, tx_data}, 64'd0);
            end else begin
                logic [8:0] e;
                e = exp_bytes.pop_front();
                check({tx_last, tx_data} == e, "R3 byte/last", {55'd0, tx_last, tx_data},
                      {55'd0, e});
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        #2;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        #2;
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Build one descriptor and push what the engine should produce.
    task automatic arm(input int slot, input int len, input logic [31:0] flags,
                       input int buf_addr, input int tagv, input bit good);
        int da;
        logic [31:0] st;
        da = BASE + slot * 16;
        st = OWN | flags | 32'(len);
        mem[da >> 2]       = st;
        mem[(da >> 2) + 1] = 32'd0;
        mem[(da >> 2) + 2] = 32'(buf_addr);
        mem[(da >> 2) + 3] = 32'd0;
        for (int k = 0; k < len; k++) begin
            logic [7:0] b;
            b = 8'(tagv * 16 + k + 1);
            mem[(buf_addr >> 2) + k / 4][8 * (k % 4) +: 8] = b;
            if (good) exp_bytes.push_back({(k == len - 1), b});
        end
        exp_wb.push_back({32'(da), st & ~OWN});
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        int acc0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        ready_mode = 1;
        run_cycles(3);
        #2 rst_n = 1'b1;
        #5;
        // R1: reset state
        check(!mem_req && !tx_valid && !irq, "R1 outputs idle",
              {61'd0, mem_req, tx_valid, irq}, 64'd0);
        reg_read(3'd2, rd);
        check(rd == 0, "R1 control reads zero", 64'(rd), 64'd0);
        reg_read(3'd4, rd);
        check(rd == 0, "R1 irq status reads zero", 64'(rd), 64'd0);

        // R2: base alignment
        reg_write(3'd0, 32'h1FF);
        reg_write(3'd1, 32'd0);
        reg_read(3'd0, rd);
        check(rd == BASE, "R2 base low byte forced zero", 64'(rd), 64'(BASE));

        // R9: poll while disabled
        acc0 = n_access;
        reg_write(3'd3, 32'd1);
        run_cycles(30);
        check(n_access == acc0, "R9 no memory access", 64'(n_access), 64'(acc0));
        reg_read(3'd4, rd);
        check(rd == 0, "R9 irq unchanged", 64'(rd), 64'd0);

        // R3 R4 R5 R6: three-entry ring, wraps on end-of-ring
        arm(0, 5, FS | LS, 32'h400, 1, 1'b1);
        arm(1, 8, FS | LS, 32'h500, 2, 1'b1);
        arm(2, 1, FS | LS | EOR, 32'h600, 3, 1'b1);
        rd_log.delete();
        reg_write(3'd2, 32'd1);
        reg_write(3'd3, 32'd1);
        run_cycles(300);
        check(rd_log.size() > 0 && rd_log[0] == BASE, "R2 first fetch at base",
              64'(rd_log.size() > 0 ? rd_log[0] : 0), 64'(BASE));
        check(rd_log.size() > 0 && rd_log[rd_log.size()-1] == BASE,
              "R6 wrap to base after end-of-ring",
              64'(rd_log.size() > 0 ? rd_log[rd_log.size()-1] : 0), 64'(BASE));
        check(exp_bytes.size() == 0, "R3 all bytes sent", 64'(exp_bytes.size()), 64'd0);
        check(exp_wb.size() == 0, "R4 all write-backs", 64'(exp_wb.size()), 64'd0);
        reg_read(3'd4, rd);
        check(rd == 32'h5, "R4/R5 done and unavailable", 64'(rd), 64'h5);
        check(irq == 1'b1, "R12 irq asserted", 64'(irq), 64'd1);
        check(!mem_req, "R5 idle after unowned", 64'(mem_req), 64'd0);

        // R8: write-one-to-clear
        reg_write(3'd4, 32'h1);
        reg_read(3'd4, rd);
        check(rd == 32'h4, "R8 clear done only", 64'(rd), 64'h4);
        reg_write(3'd4, 32'h0);
        reg_read(3'd4, rd);
        check(rd == 32'h4, "R8 zero write keeps bits", 64'(rd), 64'h4);
        reg_write(3'd4, 32'h4);
        reg_read(3'd4, rd);
        check(rd == 32'h0, "R8 all cleared", 64'(rd), 64'h0);
        check(irq == 1'b0, "R12 irq low", 64'(irq), 64'd0);

        // R11 R3: backpressure on a 7-byte frame
        ready_mode = 0;
        arm(0, 7, FS | LS, 32'h700, 4, 1'b1);
        reg_write(3'd3, 32'd1);
        run_cycles(300);
        ready_mode = 1;
        check(exp_bytes.size() == 0, "R11 stalled frame complete", 64'(exp_bytes.size()), 64'd0);
        check(exp_wb.size() == 0, "R4 stalled write-back", 64'(exp_wb.size()), 64'd0);
        reg_read(3'd4, rd);
        check(rd == 32'h5, "R4 done after stalled frame", 64'(rd), 64'h5);
        reg_write(3'd4, 32'h7);

        // R7: missing first-segment flag, then zero length
        arm(1, 4, LS, 32'h800, 5, 1'b0);
        arm(2, 0, FS | LS | EOR, 32'h900, 6, 1'b0);
        reg_write(3'd3, 32'd1);
        run_cycles(200);
        check(exp_bytes.size() == 0, "R7 no bytes", 64'(exp_bytes.size()), 64'd0);
        check(exp_wb.size() == 0, "R7 write-backs done", 64'(exp_wb.size()), 64'd0);
        reg_read(3'd4, rd);
        check(rd == 32'h6, "R7 error and unavailable", 64'(rd), 64'h6);

        // R10: soft reset returns to base
        arm(0, 2, FS | LS, 32'hA00, 7, 1'b1);
        reg_write(3'd3, 32'd1);
        run_cycles(150);
        reg_write(3'd2, 32'h3);
        run_cycles(2);
        reg_read(3'd2, rd);
        check(rd == 0, "R10 reset bit and enable cleared", 64'(rd), 64'd0);
        reg_read(3'd4, rd);
        check(rd == 0, "R10 irq cleared", 64'(rd), 64'd0);
        arm(0, 3, FS | LS, 32'hB00, 8, 1'b1);
        rd_log.delete();
        reg_write(3'd2, 32'd1);
        reg_write(3'd3, 32'd1);
        run_cycles(200);
        check(rd_log.size() > 0 && rd_log[0] == BASE, "R10 scan restarts at base",
              64'(rd_log.size() > 0 ? rd_log[0] : 0), 64'(BASE));
        check(exp_bytes.size() == 0 && exp_wb.size() == 0, "R10 frame after reset",
              64'(exp_bytes.size() + exp_wb.size()), 64'd0);

        finish_run();
    end

endmodule